// File: doc/BRIEF.md
# Return Address Shadow Stack Checker

This block runs alongside an instruction sequencer and keeps a second, protected copy of every return address in a small on-chip array. Ordinary data writes have no path into that array. When the sequencer signals a call, the block pushes the return address. When it signals a return, the block pops the top entry and compares it with the address the sequencer took from the normal program stack. If the two differ, the block raises a control-protection fault for one cycle.

The shadow pointer is a byte address. The stack grows downward in 8-byte steps and holds 64-bit entries. An empty stack has the pointer at `DEPTH*8`, and a full one has it at 0. Software can sample the pointer through a read request. It can also discard 0 to 255 entries in one unwind command, and a deeper unwind is issued as several commands in a row. Popping an empty stack or pushing onto a full one raises a dedicated fault and leaves the state alone. While the enable input is low, calls and returns pass by the checker without touching it.

Top module: `shadow_ret_checker`

## Requirements
- R1: After reset the pointer reads `DEPTH*8` (128 with defaults) and all three fault outputs are low.
- R2: An accepted call lowers the pointer by 8 and stores `call_addr` in the new top entry.
- R3: An accepted return whose `ret_addr` equals the top entry raises the pointer by 8 and raises no fault.
- R4: An accepted return whose `ret_addr` differs from the top entry still raises the pointer by 8, and `fault_cp` is high for exactly the following cycle.
- R5: A call while the pointer is 0 (full) sets `fault_ovf` for the following cycle and changes neither the pointer nor any stored entry.
- R6: A return while the pointer is `DEPTH*8` (empty) sets `fault_unf` for the following cycle, leaves the pointer unchanged and does not set `fault_cp`.
- R7: An unwind adds `8*unwind_count` to the pointer, with the count taken as an unsigned value from 0 to 255. A count of 0 changes nothing. A count that would move the pointer above `DEPTH*8` sets `fault_unf` and leaves the pointer unchanged.
- R8: A cycle with `rd_req` high is followed by a cycle with `rd_valid` high and `rd_data` equal to the pointer as it stood in the request cycle.
- R9: While `enable` is low, call and return requests neither move the pointer nor raise any fault.
- R10: When several commands arrive in the same cycle, only the highest-priority one acts. The order is call first, then return, then unwind.
- R11: The pointer always stays a multiple of 8 and never exceeds `DEPTH*8`. At most one fault output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables the checker for calls and returns |
| call_valid | input | 1 | Call event |
| call_addr | input | ENTRY_W | Return address to push |
| ret_valid | input | 1 | Return event |
| ret_addr | input | ENTRY_W | Return address from the program stack |
| unwind_valid | input | 1 | Unwind command |
| unwind_count | input | 8 | Number of entries to discard |
| rd_req | input | 1 | Pointer read request |
| rd_valid | output | 1 | Pointer read result valid |
| rd_data | output | PTR_W | Pointer value captured at the request |
| fault_cp | output | 1 | Return address mismatch fault |
| fault_ovf | output | 1 | Push on full stack fault |
| fault_unf | output | 1 | Pop or unwind past empty fault |

## Verification
The overflow case is the hardest to reach from the ports. The stack has to be filled through every slot, and only then can a further call be presented. The bench pushes sixteen distinct addresses, offers one extra call and confirms the overflow fault. It then pops all sixteen in order and compares each one, which shows that the rejected address never reached the array. The unwind-past-empty case gets the same treatment: the bench partly fills the stack, asks for one entry more than it holds, and then unwinds the exact remainder.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic [1:0] {
      SSC_IDLE   = 2'd0,
      SSC_PUSH   = 2'd1,
      SSC_POP    = 2'd2,
      SSC_UNWIND = 2'd3
   } ssc_op_e;

   localparam int unsigned SSC_STEP      = 8;
   localparam int unsigned SSC_UNWIND_W  = 8;
endpackage

// File: rtl/ssc_store.sv
module ssc_store #(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned ENTRY_W     = 64,
   parameter bit          RESET_STORE = 1'b0,
   localparam int unsigned IDX_W      = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   widx,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic [IDX_W-1:0]   ridx,
   output logic [ENTRY_W-1:0] rdata
);
   logic [ENTRY_W-1:0] slots [DEPTH];

   generate
      if (RESET_STORE) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
            end else if (we) begin
               slots[widx] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) slots[widx] <= wdata;
         end
      end
   endgenerate

   assign rdata = slots[ridx];
endmodule

// File: rtl/ssc_cmp.sv
module ssc_cmp #(
   parameter int unsigned ENTRY_W = 64
) (
   input  logic [ENTRY_W-1:0] shadow,
   input  logic [ENTRY_W-1:0] program_copy,
   output logic               same
);
   assign same = (shadow == program_copy);
endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
   import ssc_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH*SSC_STEP + 1),
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    call_valid,
   input  logic                    ret_valid,
   input  logic                    unwind_valid,
   input  logic [SSC_UNWIND_W-1:0] unwind_count,
   input  logic                    same,
   output logic [PTR_W-1:0]        ssp,
   output logic                    we,
   output logic [IDX_W-1:0]        widx,
   output logic [IDX_W-1:0]        ridx,
   output logic                    fault_cp,
   output logic                    fault_ovf,
   output logic                    fault_unf
);
   localparam int unsigned EMPTY = DEPTH * SSC_STEP;
   localparam int unsigned SUM_W = PTR_W + SSC_UNWIND_W + 4;

   ssc_op_e          op;
   logic             is_full, is_empty, unwind_bad;
   logic [PTR_W-1:0] ssp_dn, ssp_up, ssp_nx;
   logic [SUM_W-1:0] unwind_sum;

   always_comb begin
      if (enable && call_valid)      op = SSC_PUSH;
      else if (enable && ret_valid)  op = SSC_POP;
      else if (unwind_valid)         op = SSC_UNWIND;
      else                           op = SSC_IDLE;
   end

   assign is_full    = (ssp == '0);
   assign is_empty   = (ssp == PTR_W'(EMPTY));
   assign ssp_dn     = ssp - PTR_W'(SSC_STEP);
   assign ssp_up     = ssp + PTR_W'(SSC_STEP);
   assign unwind_sum = SUM_W'(ssp) + (SUM_W'(unwind_count) << 3);
   assign unwind_bad = (unwind_sum > SUM_W'(EMPTY));
   assign widx       = ssp_dn[IDX_W+2:3];
   assign ridx       = ssp[IDX_W+2:3];
   assign we         = (op == SSC_PUSH) && !is_full;

   always_comb begin
      ssp_nx = ssp;
      unique case (op)
         SSC_PUSH:   if (!is_full)    ssp_nx = ssp_dn;
         SSC_POP:    if (!is_empty)   ssp_nx = ssp_up;
         SSC_UNWIND: if (!unwind_bad) ssp_nx = unwind_sum[PTR_W-1:0];
         default:    ssp_nx = ssp;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ssp       <= PTR_W'(EMPTY);
         fault_cp  <= 1'b0;
         fault_ovf <= 1'b0;
         fault_unf <= 1'b0;
      end else begin
         ssp       <= ssp_nx;
         fault_cp  <= (op == SSC_POP) && !is_empty && !same;
         fault_ovf <= (op == SSC_PUSH) && is_full;
         fault_unf <= ((op == SSC_POP) && is_empty) ||
                      ((op == SSC_UNWIND) && unwind_bad);
      end
   end
endmodule

// File: rtl/shadow_ret_checker.sv
module shadow_ret_checker
   import ssc_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned ENTRY_W     = 64,
   parameter bit          RESET_STORE = 1'b0,
   localparam int unsigned PTR_W      = $clog2(DEPTH*SSC_STEP + 1),
   localparam int unsigned IDX_W      = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    call_valid,
   input  logic [ENTRY_W-1:0]      call_addr,
   input  logic                    ret_valid,
   input  logic [ENTRY_W-1:0]      ret_addr,
   input  logic                    unwind_valid,
   input  logic [SSC_UNWIND_W-1:0] unwind_count,
   input  logic                    rd_req,
   output logic                    rd_valid,
   output logic [PTR_W-1:0]        rd_data,
   output logic                    fault_cp,
   output logic                    fault_ovf,
   output logic                    fault_unf
);
   generate
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (ENTRY_W < 8) begin : g_bad_width
         $error("ENTRY_W must be at least 8");
      end
   endgenerate

   logic [PTR_W-1:0]   ssp;
   logic               we, same;
   logic [IDX_W-1:0]   widx, ridx;
   logic [ENTRY_W-1:0] top_entry;

   ssc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .call_valid(call_valid), .ret_valid(ret_valid),
      .unwind_valid(unwind_valid), .unwind_count(unwind_count),
      .same(same), .ssp(ssp), .we(we), .widx(widx), .ridx(ridx),
      .fault_cp(fault_cp), .fault_ovf(fault_ovf), .fault_unf(fault_unf)
   );

   ssc_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .RESET_STORE(RESET_STORE)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(call_addr),
      .ridx(ridx), .rdata(top_entry)
   );

   ssc_cmp #(.ENTRY_W(ENTRY_W)) u_cmp (
      .shadow(top_entry), .program_copy(ret_addr), .same(same)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= ssp;
      end
   end
endmodule

// File: rtl/ssc_checks.sv
module ssc_checks #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             call_valid,
   input logic             unwind_valid,
   input logic             ret_valid,
   input logic [PTR_W-1:0] ssp,
   input logic             rd_req,
   input logic             rd_valid,
   input logic [PTR_W-1:0] rd_data,
   input logic             fault_cp,
   input logic             fault_ovf,
   input logic             fault_unf
);
   localparam logic [PTR_W-1:0] EMPTY = PTR_W'(DEPTH * 8);

   a_r2_push_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && call_valid && ssp != '0) |=> (ssp == $past(ssp) - PTR_W'(8)));

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && call_valid && ssp == '0) |=> (fault_ovf && ssp == '0));

   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !call_valid && ret_valid && ssp == EMPTY) |=>
      (fault_unf && !fault_cp && ssp == EMPTY));

   a_r8_read_pointer: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (rd_valid && rd_data == $past(ssp)));

   a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !unwind_valid) |=> ($stable(ssp) && !fault_cp && !fault_ovf && !fault_unf));

   a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (ssp[2:0] == 3'b000) && (ssp <= EMPTY));

   a_r11_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_cp, fault_ovf, fault_unf}));
endmodule

bind shadow_ret_checker ssc_checks #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .call_valid(call_valid),
   .unwind_valid(unwind_valid), .ret_valid(ret_valid), .ssp(ssp),
   .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
   .fault_cp(fault_cp), .fault_ovf(fault_ovf), .fault_unf(fault_unf)
);

// File: tb/sim_shadow_ret_checker.sv
`timescale 1ns/1ps
module sim_shadow_ret_checker;
   localparam int DEPTH = 16;
   localparam int PTR_W = $clog2(DEPTH*8 + 1);
   localparam int EMPTY = DEPTH * 8;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
   logic call_valid = 1'b0, ret_valid = 1'b0, unwind_valid = 1'b0, rd_req = 1'b0;
   logic [63:0] call_addr = '0, ret_addr = '0;
   logic [7:0]  unwind_count = '0;
   logic        rd_valid, fault_cp, fault_ovf, fault_unf;
   logic [PTR_W-1:0] rd_data;
   logic f_cp, f_ovf, f_unf;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   shadow_ret_checker u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .call_valid(call_valid), .call_addr(call_addr),
      .ret_valid(ret_valid), .ret_addr(ret_addr),
      .unwind_valid(unwind_valid), .unwind_count(unwind_count),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .fault_cp(fault_cp), .fault_ovf(fault_ovf), .fault_unf(fault_unf)
   );

   function automatic logic [63:0] addr_of(input int k);
      return 64'h0000_7F00_0000_1000 + 64'(k) * 64'h34;
   endfunction

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic [63:0] ca, input logic r,
                       input logic [63:0] ra, input logic u, input logic [7:0] uc);
      @(negedge clk);
      call_valid = c; call_addr = ca; ret_valid = r; ret_addr = ra;
      unwind_valid = u; unwind_count = uc;
      @(posedge clk); #1;
      f_cp = fault_cp; f_ovf = fault_ovf; f_unf = fault_unf;
      call_valid = 0; ret_valid = 0; unwind_valid = 0;
   endtask

   task automatic read_ptr(output logic [PTR_W-1:0] p);
      @(negedge clk); rd_req = 1;
      @(posedge clk); #1;
      p = rd_data;
      check(rd_valid === 1'b1, "R8 rd_valid", 64'(rd_valid), 1);
      rd_req = 0;
   endtask

   task automatic expect_ptr(input int exp, input string req);
      logic [PTR_W-1:0] p;
      read_ptr(p);
      check(p == PTR_W'(exp), req, 64'(p), 64'(exp));
   endtask

   task automatic no_faults(input string req);
      check({f_cp, f_ovf, f_unf} == 3'b000, req, 64'({f_cp, f_ovf, f_unf}), 0);
   endtask

   task automatic t_reset;
      check({fault_cp, fault_ovf, fault_unf} == 3'b000, "R1 faults", 64'({fault_cp, fault_ovf, fault_unf}), 0);
      expect_ptr(EMPTY, "R1 pointer");
   endtask

   task automatic t_push_pop;
      for (int k = 0; k < 3; k++) step(1, addr_of(k), 0, 0, 0, 0);
      expect_ptr(EMPTY - 24, "R2 push");
      for (int k = 2; k >= 0; k--) begin
         step(0, 0, 1, addr_of(k), 0, 0);
         no_faults("R3 match");
      end
      expect_ptr(EMPTY, "R3 pop");
   endtask

   task automatic t_mismatch;
      step(1, 64'hAAAA_0000, 0, 0, 0, 0);
      step(0, 0, 1, 64'hAAAA_0008, 0, 0);
      check(f_cp === 1'b1 && !f_ovf && !f_unf, "R4 cp fault", 64'(f_cp), 1);
      @(posedge clk); #1;
      check(fault_cp === 1'b0, "R4 one cycle", 64'(fault_cp), 0);
      expect_ptr(EMPTY, "R4 pointer");
   endtask

   task automatic t_overflow;
      for (int k = 0; k < DEPTH; k++) step(1, addr_of(100 + k), 0, 0, 0, 0);
      expect_ptr(0, "R5 full");
      step(1, 64'hDEAD_BEEF, 0, 0, 0, 0);
      check(f_ovf === 1'b1, "R5 ovf fault", 64'(f_ovf), 1);
      expect_ptr(0, "R5 pointer held");
      for (int k = DEPTH - 1; k >= 0; k--) begin
         step(0, 0, 1, addr_of(100 + k), 0, 0);
         no_faults("R5 entries intact");
      end
      expect_ptr(EMPTY, "R5 drained");
   endtask

   task automatic t_underflow;
      step(0, 0, 1, 64'h1234, 0, 0);
      check(f_unf === 1'b1 && f_cp === 1'b0, "R6 unf fault", 64'({f_cp, f_unf}), 1);
      expect_ptr(EMPTY, "R6 pointer held");
   endtask

   task automatic t_unwind;
      for (int k = 0; k < 10; k++) step(1, addr_of(200 + k), 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0);
      no_faults("R7 zero");
      expect_ptr(EMPTY - 80, "R7 zero count");
      step(0, 0, 0, 0, 1, 3);
      expect_ptr(EMPTY - 56, "R7 unwind 3");
      step(0, 0, 1, addr_of(206), 0, 0);
      no_faults("R7 top after unwind");
      step(0, 0, 0, 0, 1, 7);
      check(f_unf === 1'b1, "R7 past empty", 64'(f_unf), 1);
      expect_ptr(EMPTY - 48, "R7 held");
      step(0, 0, 0, 0, 1, 255);
      check(f_unf === 1'b1, "R7 max count", 64'(f_unf), 1);
      step(0, 0, 0, 0, 1, 6);
      no_faults("R7 exact");
      expect_ptr(EMPTY, "R7 exact");
   endtask

   task automatic t_bypass;
      enable = 0;
      step(1, 64'h55, 0, 0, 0, 0);
      no_faults("R9 call");
      expect_ptr(EMPTY, "R9 call ignored");
      step(0, 0, 1, 64'h77, 0, 0);
      no_faults("R9 ret");
      expect_ptr(EMPTY, "R9 ret ignored");
      enable = 1;
   endtask

   task automatic t_priority;
      step(1, 64'hC0DE, 1, 64'h999, 1, 1);
      no_faults("R10 call wins");
      expect_ptr(EMPTY - 8, "R10 call wins");
      step(0, 0, 1, 64'hC0DE, 1, 5);
      no_faults("R10 ret wins");
      expect_ptr(EMPTY, "R10 ret wins");
   endtask

   initial begin
      #(200000 * 5);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      t_reset();
      t_push_pop();
      t_mismatch();
      t_overflow();
      t_underflow();
      t_unwind();
      t_bypass();
      t_priority();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule